// File: doc/BRIEF.md
# Strict Priority Packet Output Scheduler

This block merges complete link packets from several sources onto one byte-wide serial transmitter. A packet enters one byte per cycle with a 2-bit priority. It is held in one of four byte queues, chosen by that priority, and it becomes visible to the output side only after its final byte has been stored. Whenever the output is free, the scheduler picks the oldest complete packet in the most urgent non-empty queue. It then streams that packet byte by byte under a valid/ready handshake until the last byte has been accepted.

Selection works on whole packets and never preempts. A packet that has been picked finishes before any other packet is considered, even if a more urgent one arrives meanwhile. If traffic keeps arriving faster than the output can drain it, the less urgent queues can be starved completely while the urgent ones keep full throughput. A packet that does not fit in its queue is discarded as a whole and counted per priority. Each queue reports how many complete packets it holds.

Top module: `sps_sched`

## Requirements
- R1: After reset, txValid is 0 and every packet count and drop count is 0.
- R2: The priority is taken from inPrio on the first byte of a packet (inValid high, no packet in progress); inPrio on later bytes is ignored. The packet is stored in queue number equal to that priority. qPktCount[q*CNT_W +: CNT_W] gives the number of complete packets held in queue q, including one that is currently being sent.
- R3: When a packet is picked, it comes from the lowest-numbered queue that holds a complete packet; priority 0 is the most urgent, and less urgent queues wait for as long as more urgent ones hold packets.
- R4: Packets of the same priority leave in the order their last bytes arrived, and their bytes leave in the order they were written.
- R5: Once picked, a packet is sent to its end without interruption, even if a more urgent packet becomes complete while it is stalled or streaming.
- R6: A byte is transferred on each cycle with txValid and txReady both high. While txValid is high and txReady is low, txData and txLast hold. txLast is high exactly on the final byte of each packet.
- R7: If a byte of a packet would overflow its queue (DEPTH bytes), the whole packet is discarded: none of its bytes are ever sent, bytes already queued are kept, the space it occupied is reclaimed, and dropCount[q*DROP_W +: DROP_W] of that queue increments by one (wrapping). A packet that exactly fills the queue is kept.
- R8: The next packet is picked only in the cycle after the last byte of the previous one is accepted, so txValid is 0 for at least one cycle between packets.
- R9: When a packet becomes complete in the same cycle as another packet in the same queue finishes sending, the packet count of that queue stays exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An input byte is present this cycle |
| inData | input | DATA_W | Input byte |
| inPrio | input | 2 | Priority of the packet, sampled on its first byte |
| inLast | input | 1 | Marks the final byte of the input packet |
| txReady | input | 1 | Transmitter accepts the current byte |
| txValid | output | 1 | An output byte is presented |
| txData | output | DATA_W | Output byte |
| txLast | output | 1 | Marks the final byte of the output packet |
| qPktCount | output | 4*CNT_W | Complete packets held, per queue |
| dropCount | output | 4*DROP_W | Dropped packets, per queue |

## Verification
Two functions can land on the same cycle. A packet can become complete in a queue at the moment another packet from that same queue sends its last byte, so the packet counter has to add and subtract in one step. The bench provokes this by streaming 3-byte packets of one priority into a free-running output. It repeats the run with input gaps of zero to three cycles, so the write and read phases slide across each other. The run is judged by the exact byte order seen on the output and by the count of that queue returning to zero once everything has drained.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int PRIO_W = 2;
  localparam int NUM_Q  = 1 << PRIO_W;

  // strobes from the control to the queue datapath
  typedef struct packed {
    logic              pop;      // head byte of popQ is accepted
    logic              pktDone;  // that byte ends its packet
    logic [PRIO_W-1:0] popQ;     // queue being served
  } popCtl_t;
endpackage

// File: rtl/sps_datapath.sv
module sps_datapath
  import sps_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int DROP_W = 8,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [DATA_W-1:0]       inData,
  input  logic [PRIO_W-1:0]       inPrio,
  input  logic                    inLast,
  input  popCtl_t                 ctl,
  output logic [NUM_Q-1:0]        hasPkt,
  output logic [DATA_W-1:0]       headData,
  output logic                    headLast,
  output logic [NUM_Q*CNT_W-1:0]  qPktCount,
  output logic [NUM_Q*DROP_W-1:0] dropCount
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic              inPkt, dropping, effDrop;
  logic [PRIO_W-1:0] wrPrio, curQ;
  logic [NUM_Q-1:0]  qFull;
  logic [DATA_W:0]   headWord [NUM_Q];

  assign curQ    = inPkt ? wrPrio : inPrio;
  assign effDrop = dropping | qFull[curQ];

  // packet-level write state shared by all queues
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt    <= 1'b0;
      dropping <= 1'b0;
      wrPrio   <= '0;
    end else if (inValid) begin
      if (inLast) begin
        inPkt    <= 1'b0;
        dropping <= 1'b0;
      end else begin
        inPkt    <= 1'b1;
        wrPrio   <= curQ;
        dropping <= effDrop;
      end
    end
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    logic [DATA_W:0]   mem [DEPTH];
    logic [PW-1:0]     wrPtr, cmtPtr, rdPtr, pktCnt, used;
    logic [DROP_W-1:0] dropCnt;
    logic              wSel, doWrite, doCommit, doDrop, doPop, doDone;

    assign wSel     = inValid && (curQ == PRIO_W'(q));
    assign doWrite  = wSel && !effDrop;
    assign doCommit = doWrite && inLast;
    assign doDrop   = wSel && effDrop && inLast;
    assign doPop    = ctl.pop && (ctl.popQ == PRIO_W'(q));
    assign doDone   = doPop && ctl.pktDone;
    assign used     = wrPtr - rdPtr;
    assign qFull[q] = (used == PW'(DEPTH));

    always_ff @(posedge clk) begin
      if (doWrite) mem[wrPtr[AW-1:0]] <= {inLast, inData};
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr   <= '0;
        cmtPtr  <= '0;
        rdPtr   <= '0;
        pktCnt  <= '0;
        dropCnt <= '0;
      end else begin
        if (doWrite)     wrPtr <= wrPtr + 1'b1;
        else if (doDrop) wrPtr <= cmtPtr;          // rewind the discarded packet
        if (doCommit)    cmtPtr <= wrPtr + 1'b1;
        if (doPop)       rdPtr <= rdPtr + 1'b1;
        pktCnt <= pktCnt + PW'(doCommit) - PW'(doDone);
        if (doDrop)      dropCnt <= dropCnt + 1'b1;
      end
    end

    assign headWord[q] = mem[rdPtr[AW-1:0]];
    assign hasPkt[q]   = (pktCnt != '0);
    assign qPktCount[q*CNT_W +: CNT_W]    = CNT_W'(pktCnt);
    assign dropCount[q*DROP_W +: DROP_W]  = dropCnt;

    // R7: a queue never holds more than DEPTH bytes
    a_r7_within_depth: assert property (@(posedge clk) disable iff (!rstN)
      used <= PW'(DEPTH));
    // R9: packet count never exceeds committed bytes
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
      pktCnt <= PW'(cmtPtr - rdPtr));
  end

  assign headData = headWord[ctl.popQ][DATA_W-1:0];
  assign headLast = headWord[ctl.popQ][DATA_W];
endmodule

// File: rtl/sps_control.sv
module sps_control
  import sps_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_Q-1:0] hasPkt,
  input  logic             headLast,
  input  logic             txReady,
  output popCtl_t          ctl,
  output logic             txValid
);
  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  state_t            state;
  logic [PRIO_W-1:0] selQ, pick;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_Q - 1; i >= 0; i--) begin
      if (hasPkt[i]) pick = PRIO_W'(i);
    end
  end

  assign txValid     = (state == ST_SEND);
  assign ctl.pop     = txValid && txReady;
  assign ctl.pktDone = ctl.pop && headLast;
  assign ctl.popQ    = selQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      selQ  <= '0;
    end else if (state == ST_IDLE) begin
      if (|hasPkt) begin
        state <= ST_SEND;
        selQ  <= pick;
      end
    end else if (ctl.pktDone) begin
      state <= ST_IDLE;
    end
  end

  // R3: a waiting packet is picked at once, urgent queue 0 first
  a_r3_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && |hasPkt) |=> (state == ST_SEND));
  a_r3_urgent_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && hasPkt[0]) |=> (selQ == '0));
  // R5: no switch of queue before the packet ends
  a_r5_no_preempt: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && !ctl.pktDone) |=> (state == ST_SEND && $stable(selQ)));
  // R8: one idle cycle after each packet
  a_r8_gap: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pktDone |=> !txValid);
endmodule

// File: rtl/sps_sched.sv
module sps_sched
  import sps_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int DROP_W = 8,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [DATA_W-1:0]       inData,
  input  logic [PRIO_W-1:0]       inPrio,
  input  logic                    inLast,
  input  logic                    txReady,
  output logic                    txValid,
  output logic [DATA_W-1:0]       txData,
  output logic                    txLast,
  output logic [NUM_Q*CNT_W-1:0]  qPktCount,
  output logic [NUM_Q*DROP_W-1:0] dropCount
);
  popCtl_t          ctl;
  logic [NUM_Q-1:0] hasPkt;

  sps_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DROP_W(DROP_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inPrio(inPrio),
    .inLast(inLast), .ctl(ctl), .hasPkt(hasPkt), .headData(txData),
    .headLast(txLast), .qPktCount(qPktCount), .dropCount(dropCount)
  );

  sps_control u_ctl (
    .clk(clk), .rstN(rstN), .hasPkt(hasPkt), .headLast(txLast),
    .txReady(txReady), .ctl(ctl), .txValid(txValid)
  );

  // R6: a stalled byte is held unchanged
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));
endmodule

// File: tb/sps_sched_test.sv
module sps_sched_test;
  import sps_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int DROP_W = 8;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    inValid = 1'b0;
  logic [DATA_W-1:0]       inData = '0;
  logic [PRIO_W-1:0]       inPrio = '0;
  logic                    inLast = 1'b0;
  logic                    txReady;
  logic                    txValid;
  logic [DATA_W-1:0]       txData;
  logic                    txLast;
  logic [NUM_Q*CNT_W-1:0]  qPktCount;
  logic [NUM_Q*DROP_W-1:0] dropCount;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;
  bit  hold = 1;
  bit  stallMode = 0;
  int  cyc = 0;
  bit  prevLast = 0;
  int  expQ[$];

  sps_sched #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DROP_W(DROP_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inPrio(inPrio),
    .inLast(inLast), .txReady(txReady), .txValid(txValid), .txData(txData),
    .txLast(txLast), .qPktCount(qPktCount), .dropCount(dropCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // output back-pressure pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 txReady = hold ? 1'b0 : (stallMode ? ((cyc % 3) != 0) : 1'b1);
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pktOf(int q);
    return int'(qPktCount[q*CNT_W +: CNT_W]);
  endfunction

  function automatic int dropOf(int q);
    return int'(dropCount[q*DROP_W +: DROP_W]);
  endfunction

  // drives one packet; later bytes carry a different inPrio to prove it is ignored (R2)
  task automatic sendPkt(int prio, int len, int base, int gap);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inData  = DATA_W'(base + i);
      inPrio  = (i == 0) ? PRIO_W'(prio) : PRIO_W'(3 - prio);
      inLast  = (i == len - 1);
      @(posedge clk); #1;
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  task automatic expectPkt(int base, int len);
    for (int i = 0; i < len; i++)
      expQ.push_back(((i == len - 1) ? 256 : 0) | ((base + i) & 255));
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0 || txValid) begin @(posedge clk); #1; end
    repeat (3) begin @(posedge clk); #1; end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (prevLast) check(!txValid, "R8 idle gap after packet", int'(txValid), 0);
      if (txValid && txReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 R4 R7 unexpected output byte", int'({txLast, txData}), -1);
        end else begin
          int e;
          e = expQ.pop_front();
          check({23'd0, txLast, txData} == e, "R3 R4 R5 R6 output byte order", int'({txLast, txData}), e);
        end
      end
      prevLast = txValid && txReady && txLast;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    check(!txValid, "R1 txValid after reset", int'(txValid), 0);
    for (int q = 0; q < NUM_Q; q++) begin
      check(pktOf(q) == 0, "R1 packet count", pktOf(q), 0);
      check(dropOf(q) == 0, "R1 drop count", dropOf(q), 0);
    end

    // R2 R3 R4 R5: load with output held; the first complete packet is picked at once
    hold = 1;
    sendPkt(3, 2, 'h30, 1);
    sendPkt(2, 3, 'h20, 0);
    sendPkt(0, 2, 'h00, 0);
    sendPkt(2, 2, 'h28, 0);
    sendPkt(1, 4, 'h10, 2);
    check(pktOf(0) == 1, "R2 queue 0 count", pktOf(0), 1);
    check(pktOf(1) == 1, "R2 queue 1 count", pktOf(1), 1);
    check(pktOf(2) == 2, "R2 queue 2 count", pktOf(2), 2);
    check(pktOf(3) == 1, "R2 queue 3 count", pktOf(3), 1);
    check(txValid && txData == 8'h30, "R5 picked packet stays at head", int'(txData), 'h30);
    expectPkt('h30, 2);
    expectPkt('h00, 2);
    expectPkt('h10, 4);
    expectPkt('h20, 3);
    expectPkt('h28, 2);
    stallMode = 1;
    hold = 0;
    waitDrain();
    for (int q = 0; q < NUM_Q; q++)
      check(pktOf(q) == 0, "R2 queue empty after drain", pktOf(q), 0);

    // R7: exact fill kept, whole packets dropped when full
    hold = 1;
    stallMode = 0;
    sendPkt(2, 10, 'h40, 0);
    sendPkt(2, 6, 'h60, 0);
    sendPkt(2, 1, 'h70, 0);
    sendPkt(2, 4, 'h80, 0);
    sendPkt(0, 3, 'hA0, 2);
    check(pktOf(2) == 2, "R7 queue 2 keeps exact fill", pktOf(2), 2);
    check(dropOf(2) == 2, "R7 queue 2 drop count", dropOf(2), 2);
    check(dropOf(0) == 0, "R7 queue 0 unaffected", dropOf(0), 0);
    check(pktOf(0) == 1, "R7 other queue still accepts", pktOf(0), 1);
    expectPkt('h40, 10);
    expectPkt('hA0, 3);
    expectPkt('h60, 6);
    hold = 0;
    waitDrain();
    check(dropOf(2) == 2, "R7 drop count persists", dropOf(2), 2);

    // R7: packet overflowing partway is discarded and its space reclaimed
    hold = 1;
    sendPkt(1, 12, 'h00, 0);
    sendPkt(1, 6, 'hC0, 0);
    sendPkt(1, 4, 'hD0, 2);
    check(dropOf(1) == 1, "R7 partial overflow dropped", dropOf(1), 1);
    check(pktOf(1) == 2, "R7 later packet fits after rewind", pktOf(1), 2);
    expectPkt('h00, 12);
    expectPkt('hD0, 4);
    hold = 0;
    waitDrain();

    // R9: completion and commit of the same queue sliding across each other
    for (int gap = 0; gap < 4; gap++) begin
      for (int k = 0; k < 5; k++) begin
        expectPkt(gap * 'h20 + k * 4, 3);
        sendPkt(1, 3, gap * 'h20 + k * 4, gap);
      end
      waitDrain();
      check(pktOf(1) == 0, "R9 count exact after overlap", pktOf(1), 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule